// File: doc/BRIEF.md
# Sector Lock Pulse Sequencer

This block runs, from the host side, the in-system procedures that set and clear the hardware write locks of a flash array's sectors. On a start request it raises a high-voltage request for the flash reset line and waits for the matching acknowledge. It then waits a short settling time and runs pulse and verify rounds over a plain single-beat bus port. Each round writes a setup command to a sector address, dwells for a fixed pulse time, writes a verify command and reads a status byte back. A failed read leads to another pulse, and this repeats until the sector passes or the pulse counter reaches its limit.

Two operations exist. A lock operation works through a chosen list of sectors in ascending order. An unlock operation first locks every sector, because the clearing pulse acts on all sectors at once and must only be applied to a fully locked array. It then issues clearing pulses and verifies the sectors one by one. At the end, pass or fail, the sequencer withdraws the high-voltage request, waits for the acknowledge to drop, writes a reset command and reports completion. Dwell times are given in nanoseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `lockpulse_seq`

## Requirements
- R1: After reset `busy`, `done`, `fail`, `hv_req` and `bus_valid` are all 0.
- R2: A start raises `hv_req`. No bus transfer takes place until `hv_ack` is 1 and a settle time of 1 µs (rounded up to whole cycles, at least one) has passed. Every setup command write happens while `hv_ack` is 1.
- R3: A lock round writes 60h to the sector address with low address bits [6]=0, [1]=1, [0]=0 and all other low bits zero. The sector index sits in `bus_addr[AW-1:7]`. The round then waits at least 150 µs worth of cycles, writes 40h to the same address and reads that same address. Read data 01h means the sector is locked.
- R4: The pulse counter is 1 at the first pulse of every sector and rises by one after each failed verify. When the count would reach PROT_MAX the operation ends with `fail`=1. A sector therefore receives at most PROT_MAX-1 lock pulses, and no later sector is touched.
- R5: A lock operation (`op_unlock`=0) pulses only the sectors whose `sec_mask` bit is 1, in ascending index order.
- R6: An unlock operation (`op_unlock`=1) first gives every sector its own lock round in ascending order, with the same pass and retry rules as R3 and R4. Only then does it issue any clearing pulse, and it issues no lock pulse afterwards.
- R7: A clearing round writes 60h with low address bits [6]=1, [1]=1, [0]=0, waits at least 15 ms worth of cycles, writes 40h and reads back. Read data 00h means the sector is unlocked. The first clearing pulse goes to sector 0. Sectors are then verified in ascending order, and a further clearing pulse is issued only after a failed verify.
- R8: In the unlock phase the counter restarts at 1 for each sector verified. When a failed verify would bring it to UNPROT_MAX, the operation ends with `fail`=1.
- R9: On completion `hv_req` drops first. Once `hv_ack` is 0, one write of F0h to address 0 follows. Then `done` pulses for exactly one cycle and `busy` returns to 0, with `fail` giving the result until the next start.
- R10: While `bus_valid` is 1 and `bus_ready` is 0, `bus_valid`, `bus_we`, `bus_addr` and `bus_wdata` hold their values.
- R11: A start while `busy` is 1 is ignored. The running operation keeps its operation and sector list, and no second operation follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, taken only when idle |
| op_unlock | input | 1 | 0 = lock the listed sectors, 1 = unlock all sectors |
| sec_mask | input | NSEC | Sectors to lock in a lock operation |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last operation, 1 = retry limit hit |
| hv_req | output | 1 | Request for high voltage on the flash reset line |
| hv_ack | input | 1 | High voltage present |
| bus_valid | output | 1 | Bus transfer request |
| bus_ready | input | 1 | Transfer accepted in this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | clog2(NSEC)+7 | Sector index above seven low mode bits |
| bus_wdata | output | 8 | Command byte |
| bus_rdata | input | 8 | Status byte, sampled when a read is accepted |

## Verification
The bench builds the block with NSEC=4, CLK_HZ=20000 and UNPROT_MAX=5. At that clock the settle, lock and clear dwells are 1, 3 and 300 cycles. The lock limit keeps its default of 25, so the 24-pulse pass and the 25th-count failure both fit in a short run. The small unlock limit makes exhaustion in the unlock phase reachable in a few clearing pulses, both for a slow array and for one sector that never clears.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam logic [7:0] CMD_SETUP  = 8'h60;
    localparam logic [7:0] CMD_VERIFY = 8'h40;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] STAT_LOCKED = 8'h01;
    localparam logic [7:0] STAT_OPEN   = 8'h00;
    localparam int         LOW_BITS   = 7;

    // dwell times in nanoseconds
    localparam longint unsigned SETTLE_NS = 64'd1_000;
    localparam longint unsigned LOCK_NS   = 64'd150_000;
    localparam longint unsigned OPEN_NS   = 64'd15_000_000;

    typedef enum logic [3:0] {
        S_IDLE, S_HV_UP, S_SETTLE, S_SCAN, S_PULSE, S_DWELL,
        S_VWR, S_VRD, S_HV_DN, S_RSTCMD, S_FIN
    } seq_state_e;

    typedef enum logic {PH_LOCK, PH_OPEN} phase_e;

    typedef struct packed {
        logic                valid;
        logic                we;
        logic [7:0]          data;
        logic [LOW_BITS-1:0] low;
        logic                base;   // 1: address forced to zero
    } bus_req_t;

    function automatic longint unsigned ns_to_cycles(longint unsigned hz,
                                                     longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 64'd0) ? 64'd1 : c;
    endfunction

    function automatic logic [LOW_BITS-1:0] mode_bits(phase_e ph);
        logic [LOW_BITS-1:0] a;
        a    = '0;
        a[6] = (ph == PH_OPEN);
        a[1] = 1'b1;
        a[0] = 1'b0;
        return a;
    endfunction

endpackage

// File: rtl/lp_timer.sv
module lp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0) && !load;

    AST_TIMER_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (expired) |=> (cnt == '0) || $past(load)); // R3

endmodule

// File: rtl/lp_pulse_ctr.sv
module lp_pulse_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= W'(1);
        else if (inc)
            count <= count + 1'b1;
    end

    assign last = (({1'b0, count} + 1'b1) == {1'b0, limit});

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |-> !last); // R4

    AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        count != '0); // R8

endmodule

// File: rtl/lockpulse_seq.sv
module lockpulse_seq #(
    parameter int              NSEC       = 8,
    parameter longint unsigned CLK_HZ     = 100_000_000,
    parameter int              PROT_MAX   = 25,
    parameter int              UNPROT_MAX = 1000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      op_unlock,
    input  logic [NSEC-1:0]           sec_mask,
    output logic                      busy,
    output logic                      done,
    output logic                      fail,
    output logic                      hv_req,
    input  logic                      hv_ack,
    output logic                      bus_valid,
    input  logic                      bus_ready,
    output logic                      bus_we,
    output logic [$clog2(NSEC)+6:0]   bus_addr,
    output logic [7:0]                bus_wdata,
    input  logic [7:0]                bus_rdata
);
    import lp_pkg::*;

    localparam int SW = $clog2(NSEC);
    localparam int IW = $clog2(NSEC + 1);
    localparam longint unsigned SET_CYC  = ns_to_cycles(CLK_HZ, SETTLE_NS);
    localparam longint unsigned LOCK_CYC = ns_to_cycles(CLK_HZ, LOCK_NS);
    localparam longint unsigned OPEN_CYC = ns_to_cycles(CLK_HZ, OPEN_NS);
    localparam longint unsigned MAX_CYC =
        (OPEN_CYC > LOCK_CYC) ? ((OPEN_CYC > SET_CYC) ? OPEN_CYC : SET_CYC)
                              : ((LOCK_CYC > SET_CYC) ? LOCK_CYC : SET_CYC);
    localparam int TW = $clog2(MAX_CYC + 1);
    localparam int LIM_MAX = (PROT_MAX > UNPROT_MAX) ? PROT_MAX : UNPROT_MAX;
    localparam int CW = $clog2(LIM_MAX + 1);

    seq_state_e    st, st_n;
    phase_e        phase, phase_n;
    logic [IW-1:0] idx, idx_n;
    logic          fail_q, fail_n;
    logic          op_q;
    logic [NSEC-1:0] mask_q;

    logic          tim_load, tim_exp;
    logic [TW-1:0] tim_val;
    logic          cnt_clr, cnt_inc, cnt_last;
    logic [CW-1:0] cnt_val, cnt_lim;
    logic          xfer, pass;
    bus_req_t      req;

    assign cnt_lim = (phase == PH_OPEN) ? CW'(UNPROT_MAX) : CW'(PROT_MAX);
    assign xfer    = bus_valid && bus_ready;
    assign pass    = (bus_rdata == ((phase == PH_OPEN) ? STAT_OPEN : STAT_LOCKED));

    lp_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tim_load), .val(tim_val), .expired(tim_exp)
    );

    lp_pulse_ctr #(.W(CW)) u_ctr (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
        .limit(cnt_lim), .count(cnt_val), .last(cnt_last)
    );

    // bus request formed from the current state
    always_comb begin
        req = '0;
        case (st)
            S_PULSE:  begin req.valid = 1'b1; req.we = 1'b1; req.data = CMD_SETUP;
                            req.low = mode_bits(phase); end
            S_VWR:    begin req.valid = 1'b1; req.we = 1'b1; req.data = CMD_VERIFY;
                            req.low = mode_bits(phase); end
            S_VRD:    begin req.valid = 1'b1; req.we = 1'b0;
                            req.low = mode_bits(phase); end
            S_RSTCMD: begin req.valid = 1'b1; req.we = 1'b1; req.data = CMD_RESET;
                            req.base = 1'b1; end
            default:  req = '0;
        endcase
    end

    assign bus_valid = req.valid;
    assign bus_we    = req.we;
    assign bus_wdata = req.data;
    assign bus_addr  = req.base ? '0 : {idx[SW-1:0], req.low};

    // sequencing
    always_comb begin
        st_n     = st;
        phase_n  = phase;
        idx_n    = idx;
        fail_n   = fail_q;
        tim_load = 1'b0;
        tim_val  = (phase == PH_OPEN) ? TW'(OPEN_CYC) : TW'(LOCK_CYC);
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        case (st)
            S_IDLE: if (start) begin
                st_n    = S_HV_UP;
                phase_n = PH_LOCK;
                idx_n   = '0;
                fail_n  = 1'b0;
            end
            S_HV_UP: if (hv_ack) begin
                tim_load = 1'b1;
                tim_val  = TW'(SET_CYC);
                st_n     = S_SETTLE;
            end
            S_SETTLE: if (tim_exp) st_n = S_SCAN;
            S_SCAN: begin
                if (idx == IW'(NSEC)) begin
                    if (op_q && phase == PH_LOCK) begin
                        phase_n = PH_OPEN;
                        idx_n   = '0;
                        cnt_clr = 1'b1;
                        st_n    = S_PULSE;
                    end else begin
                        st_n = S_HV_DN;
                    end
                end else if (op_q || mask_q[idx[SW-1:0]]) begin
                    cnt_clr = 1'b1;
                    st_n    = S_PULSE;
                end else begin
                    idx_n = idx + 1'b1;
                end
            end
            S_PULSE: if (xfer) begin
                tim_load = 1'b1;
                st_n     = S_DWELL;
            end
            S_DWELL: if (tim_exp) st_n = S_VWR;
            S_VWR:   if (xfer) st_n = S_VRD;
            S_VRD: if (xfer) begin
                if (pass) begin
                    if (phase == PH_LOCK) begin
                        idx_n = idx + 1'b1;
                        st_n  = S_SCAN;
                    end else if (idx == IW'(NSEC - 1)) begin
                        st_n = S_HV_DN;
                    end else begin
                        idx_n   = idx + 1'b1;
                        cnt_clr = 1'b1;
                        st_n    = S_VWR;
                    end
                end else if (cnt_last) begin
                    fail_n = 1'b1;
                    st_n   = S_HV_DN;
                end else begin
                    cnt_inc = 1'b1;
                    st_n    = S_PULSE;
                end
            end
            S_HV_DN:  if (!hv_ack) st_n = S_RSTCMD;
            S_RSTCMD: if (xfer) st_n = S_FIN;
            S_FIN:    st_n = S_IDLE;
            default:  st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            phase  <= PH_LOCK;
            idx    <= '0;
            fail_q <= 1'b0;
            op_q   <= 1'b0;
            mask_q <= '0;
        end else begin
            st     <= st_n;
            phase  <= phase_n;
            idx    <= idx_n;
            fail_q <= fail_n;
            if (st == S_IDLE && start) begin
                op_q   <= op_unlock;
                mask_q <= sec_mask;
            end
        end
    end

    assign busy   = (st != S_IDLE);
    assign done   = (st == S_FIN);
    assign fail   = fail_q;
    assign hv_req = (st == S_HV_UP) || (st == S_SETTLE) || (st == S_SCAN) ||
                    (st == S_PULSE) || (st == S_DWELL) || (st == S_VWR) ||
                    (st == S_VRD);

    AST_SETUP_UNDER_HV: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && bus_wdata == CMD_SETUP) |-> hv_ack); // R2

    AST_RESET_AFTER_HV: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && bus_wdata == CMD_RESET) |-> (!hv_req && !hv_ack)); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                       $stable(bus_wdata) && $stable(bus_we))); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(op_q) && $stable(mask_q))); // R11

    AST_NO_LOCK_AFTER_OPEN: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OPEN && st != S_IDLE && st_n != S_IDLE) |=> phase == PH_OPEN); // R6

endmodule

// File: tb/tb_lockpulse_seq.sv
module tb_lockpulse_seq;

    localparam int NS      = 4;
    localparam int PMAX    = 25;
    localparam int UMAX    = 5;
    localparam int EXP_SET  = 1;    // 1 us at 20 kHz, rounded up
    localparam int EXP_LOCK = 3;    // 150 us at 20 kHz
    localparam int EXP_OPEN = 300;  // 15 ms at 20 kHz
    localparam int AW      = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          op_unlock = 1'b0;
    logic [NS-1:0] sec_mask = '0;
    logic          busy, done, fail, hv_req;
    logic          hv_ack = 1'b0;
    logic          bus_valid, bus_we;
    logic          bus_ready = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic [7:0]    bus_rdata = 8'h00;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // array model
    bit prot[NS];
    bit prot0[NS];
    int pneed[NS];
    bit stuck[NS];
    int uneed;
    int pcnt[NS];
    int ucnt;
    int rstw;
    // expectations
    int epc[NS];
    int eu;
    bit efail;
    // per-operation monitor state
    bit cur_op;
    logic [NS-1:0] cur_mask;
    int last_sec;
    bit opened_seen;
    bit any_xfer;
    int hv_up_cyc;
    int pulse_cyc;
    bit vpend;
    logic [AW-1:0] vaddr;
    bit pend;
    logic [AW-1:0] pend_addr;
    logic [7:0] pend_data;
    logic pend_we;

    lockpulse_seq #(
        .NSEC(NS), .CLK_HZ(20_000), .PROT_MAX(PMAX), .UNPROT_MAX(UMAX)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .op_unlock(op_unlock),
        .sec_mask(sec_mask), .busy(busy), .done(done), .fail(fail),
        .hv_req(hv_req), .hv_ack(hv_ack), .bus_valid(bus_valid),
        .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic handle_xfer();
        int s;
        logic [6:0] low;
        s   = int'(bus_addr[AW-1:7]);
        low = bus_addr[6:0];
        if (bus_we) begin
            case (bus_wdata)
                8'h60: begin
                    chk(hv_ack, "R2", "setup write without hv_ack", 0, 1);
                    if (low == 7'b0000010) begin
                        if (!cur_op) chk(cur_mask[s], "R5", "pulse on unlisted sector", s, -1);
                        chk(s >= last_sec, "R5", "lock order", s, last_sec);
                        if (cur_op) chk(!opened_seen, "R6", "lock pulse after clear pulse", s, -1);
                        last_sec = s;
                        pcnt[s]++;
                        if (pcnt[s] >= pneed[s]) prot[s] = 1'b1;
                    end else if (low == 7'b1000010) begin
                        chk(cur_op, "R7", "clear pulse in lock operation", 1, 0);
                        if (!opened_seen) chk(s == 0, "R7", "first clear pulse sector", s, 0);
                        opened_seen = 1'b1;
                        ucnt++;
                        if (ucnt >= uneed)
                            for (int k = 0; k < NS; k++) if (!stuck[k]) prot[k] = 1'b0;
                    end else begin
                        chk(1'b0, "R3", "setup low address bits", int'(low), 2);
                    end
                    pulse_cyc = cyc;
                end
                8'h40: begin
                    chk(low == 7'b0000010 || low == 7'b1000010, "R3", "verify low bits", int'(low), 2);
                    chk(cyc - pulse_cyc >= (low[6] ? EXP_OPEN : EXP_LOCK),
                        low[6] ? "R7" : "R3", "dwell cycles", cyc - pulse_cyc,
                        low[6] ? EXP_OPEN : EXP_LOCK);
                    vpend = 1'b1;
                    vaddr = bus_addr;
                end
                8'hF0: begin
                    chk(!hv_ack && !hv_req, "R9", "reset cmd while high voltage", int'(hv_ack), 0);
                    chk(bus_addr == '0, "R9", "reset cmd address", int'(bus_addr), 0);
                    rstw++;
                end
                default: chk(1'b0, "R3", "unknown write data", int'(bus_wdata), 8'h40);
            endcase
            if (!any_xfer) begin
                chk(cyc - hv_up_cyc >= EXP_SET, "R2", "settle before first transfer",
                    cyc - hv_up_cyc, EXP_SET);
                any_xfer = 1'b1;
            end
        end else begin
            chk(vpend && bus_addr == vaddr, "R3", "read address", int'(bus_addr), int'(vaddr));
            bus_rdata = prot[s] ? 8'h01 : 8'h00;
            vpend = 1'b0;
        end
    endtask

    // bus and high-voltage responder, sampled at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            bus_ready = 1'b0;
            hv_ack    = 1'b0;
            pend      = 1'b0;
        end else begin
            if (pend) begin
                chk(bus_valid && bus_addr == pend_addr && bus_wdata == pend_data &&
                    bus_we == pend_we, "R10", "request held", int'(bus_addr), int'(pend_addr));
            end
            if (bus_ready) begin
                bus_ready = 1'b0;
                pend = bus_valid;
            end else if (bus_valid && $urandom_range(0, 3) != 0) begin
                handle_xfer();
                bus_ready = 1'b1;
                pend = 1'b0;
            end else begin
                pend = bus_valid;
            end
            pend_addr = bus_addr;
            pend_data = bus_wdata;
            pend_we   = bus_we;
            if (hv_ack != hv_req && $urandom_range(0, 2) == 0) begin
                hv_ack = hv_req;
                if (hv_req) hv_up_cyc = cyc;
            end
        end
    end

    task automatic predict(input bit op, input logic [NS-1:0] mask);
        bit stop;
        int u;
        int cnt;
        efail = 1'b0;
        eu = 0;
        stop = 1'b0;
        for (int s = 0; s < NS; s++) begin
            int n;
            epc[s] = 0;
            if (stop || !(op || mask[s])) continue;
            n = prot0[s] ? 1 : pneed[s];
            if (n <= PMAX - 1) epc[s] = n;
            else begin epc[s] = PMAX - 1; efail = 1'b1; stop = 1'b1; end
        end
        if (op && !efail) begin
            u = 1;
            for (int s = 0; s < NS && !stop; s++) begin
                cnt = 1;
                while (!(!stuck[s] && u >= uneed)) begin
                    if (cnt + 1 == UMAX) begin efail = 1'b1; stop = 1'b1; break; end
                    cnt++;
                    u++;
                end
            end
            eu = u;
        end
    endtask

    task automatic run_check(input bit op, input logic [NS-1:0] mask, input int poke);
        int n;
        bit stray;
        for (int s = 0; s < NS; s++) begin prot[s] = prot0[s]; pcnt[s] = 0; end
        ucnt = 0; rstw = 0; last_sec = 0; opened_seen = 1'b0; any_xfer = 1'b0;
        vpend = 1'b0;
        cur_op = op; cur_mask = mask;
        predict(op, mask);
        @(negedge clk);
        start = 1'b1; op_unlock = op; sec_mask = mask;
        @(negedge clk);
        start = 1'b0;
        chk(busy && hv_req, "R2", "busy and hv_req after start", int'(hv_req), 1);
        n = 0;
        while (!done) begin
            @(negedge clk);
            n++;
            if (poke > 0 && n == poke && !done) begin
                start = 1'b1; op_unlock = !op; sec_mask = ~mask;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(fail == efail, op ? "R8" : "R4", "fail flag", int'(fail), int'(efail));
        for (int s = 0; s < NS; s++)
            chk(pcnt[s] == epc[s], op ? "R6" : "R5", "lock pulses per sector", pcnt[s], epc[s]);
        chk(ucnt == eu, "R7", "clear pulses", ucnt, eu);
        chk(rstw == 1, "R9", "reset command count", rstw, 1);
        @(negedge clk);
        chk(!done && !busy, "R9", "done is one cycle", int'(done), 0);
        stray = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (busy || bus_valid || hv_req) stray = 1'b1;
        end
        chk(!stray, "R11", "no operation after completion", int'(stray), 0);
    endtask

    task automatic clear_model();
        for (int s = 0; s < NS; s++) begin
            prot0[s] = 1'b0; pneed[s] = 1; stuck[s] = 1'b0;
        end
        uneed = 1;
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !hv_req && !bus_valid, "R1", "reset outputs",
            int'({busy, done, fail, hv_req, bus_valid}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fail && !hv_req && !bus_valid, "R1", "idle after reset",
            int'({busy, done, fail, hv_req, bus_valid}), 0);

        // R3 R5: listed sectors, several pulses each
        clear_model();
        pneed[0] = 1; pneed[1] = 2; pneed[2] = 3; pneed[3] = 2;
        run_check(1'b0, 4'b1011, 0);

        // R4: 24 pulses passes, boundary
        clear_model();
        pneed[1] = 24; prot0[2] = 1'b1;
        run_check(1'b0, 4'b0110, 0);

        // R4: limit reached at sector 1, later sectors untouched
        clear_model();
        pneed[1] = 25;
        run_check(1'b0, 4'b1111, 0);

        // R6 R7: unlock passes after three clearing pulses
        clear_model();
        prot0[0] = 1'b1; prot0[2] = 1'b1; pneed[1] = 2; pneed[3] = 3; uneed = 3;
        run_check(1'b1, 4'b0000, 0);

        // R8: UNPROT_MAX-1 pulses passes, one more fails
        clear_model();
        uneed = UMAX - 1;
        run_check(1'b1, 4'b0000, 0);
        clear_model();
        uneed = UMAX;
        run_check(1'b1, 4'b0000, 0);

        // R8: counter restarts per sector; sector 2 never clears
        clear_model();
        uneed = 2; stuck[2] = 1'b1;
        run_check(1'b1, 4'b0000, 0);

        // R6: lock phase failure stops before clearing
        clear_model();
        pneed[3] = 30;
        run_check(1'b1, 4'b0000, 0);

        // R11: start while busy ignored
        clear_model();
        pneed[0] = 3; pneed[2] = 2;
        run_check(1'b0, 4'b0101, 6);

        // constrained random mix
        for (int k = 0; k < 8; k++) begin
            bit op;
            logic [NS-1:0] m;
            clear_model();
            op = 1'($urandom_range(0, 1));
            m  = NS'($urandom);
            for (int s = 0; s < NS; s++) begin
                prot0[s] = 1'($urandom_range(0, 1));
                pneed[s] = ($urandom_range(0, 7) == 0) ? $urandom_range(23, 26)
                                                       : $urandom_range(1, 4);
                stuck[s] = ($urandom_range(0, 9) == 0);
            end
            uneed = $urandom_range(1, UMAX);
            run_check(op, m, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule